// File: doc/BRIEF.md
# Transmit Pool with Cyclic Repeat

This block is a 32-byte transmit pool that a processor fills over a write port, one byte or one 16-bit word at a time. A write to an 8-bit command register starts the pool draining onto a single-bit serial line. Each byte goes out least significant bit first, one bit on every cycle in which the line-rate enable is high. A word write stores its low byte first, so the low byte is also sent first. Once the pool has drained, the line carries idle ones.

One command combination turns on cyclic repeat: the repeat bit (bit 5) together with the transparent-transmit bit (bit 2), for example 0x24. The pool contents are then replayed without end and without any flag or check-sequence framing. Repeat stays on only while every later command write keeps bit 5 set. A command write with bit 5 clear ends it, and so does a transmitter reset or a signaling-controller reset. A sticky pool-ready interrupt tells the processor when it may load a new block.

The controller has three states. In `ST_LOAD` the pool accepts data and the line is idle. In `ST_SEND` the pool makes one pass. In `ST_CYCLE` the pool repeats. Transitions:
- **LOAD→SEND**: a command with bit 2 or bit 3 set, bit 5 clear, and a non-empty pool.
- **LOAD→CYCLE**: a command with bits 5 and 2 set and a non-empty pool.
- **SEND→LOAD**: on the last bit, or on a reset command.
- **CYCLE→LOAD**: on a command write with bit 5 clear, or on a reset command.
- **LOAD→LOAD**: a reset command empties the pool.

Top module: `txpool_top`

## Requirements
- R1: After reset, `tx_serial` is 1, `pool_irq` is 1 and the pool is empty.
- R2: A byte write (`fifo_word`=0) stores `fifo_data[7:0]`. A word write (`fifo_word`=1) stores `fifo_data[7:0]` and then `fifo_data[15:8]`. The pool holds 32 bytes. A write that does not fit entirely is dropped, and that includes a word write when only one byte is free.
- R3: Bytes leave in write order, least significant bit first. The first bit appears on `tx_serial` on the clock after the command is taken, and each following bit appears on the next enabled clock.
- R4: A command with bit 2 or bit 3 set and bit 5 clear sends the stored bytes once. After that pass the pool is empty, `pool_irq` is set, and `tx_serial` returns to 1 on the following clock and stays at 1.
- R5: A command with bits 5 and 2 both set starts cyclic repeat. Byte 0 follows the last stored byte with no gap and no extra bits.
- R6: During cyclic repeat, a command write with bit 5 set (and bits 4 and 0 clear) does not disturb the stream. A command write with bit 5 clear ends it: one more bit goes out, `tx_serial` is 1 from the next clock on, the pool is emptied and `pool_irq` is set.
- R7: A command with bit 4 (transmitter reset) or bit 0 (signaling reset) set works in any state and takes priority over the repeat bit. One more bit goes out, `tx_serial` is 1 from the next clock on, the pool is emptied and `pool_irq` is set.
- R8: `pool_irq` is sticky and is cleared by `irq_ack`. If a set event and an acknowledge fall on the same clock, the set wins.
- R9: While a pass or a repeat is running, data writes are ignored. Command bits 7, 6 and 1 have no effect. A transmit command given while the pool is empty has no effect.
- R10: While `tx_bit_en` is low, `tx_serial` and the serializer position hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_wr | input | 1 | Pool data write strobe |
| fifo_word | input | 1 | 1 = 16-bit write, 0 = byte write |
| fifo_data | input | 16 | Write data, low byte first |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_data | input | 8 | Command value |
| irq_ack | input | 1 | Clears the pool-ready interrupt |
| tx_bit_en | input | 1 | Line-rate enable, one bit per enabled clock |
| tx_serial | output | 1 | Serial line, idle 1 |
| pool_irq | output | 1 | Sticky pool-ready interrupt |

## Verification
The bench builds the block with its default depth of 32 bytes. At that depth it can sweep every fill level from 1 to 32 bytes and compare each serial bit against values it computes arithmetically. The same depth also covers the exact-full and one-short boundaries where byte and word writes stop fitting. Cyclic repeat is checked over several whole passes, with keep-alive writes, a stop write and a reset landing mid-stream.

// File: rtl/txpool_pkg.sv
package txpool_pkg;
    // command register bit positions (bit order is decoded behaviour)
    localparam int C_ACKRX  = 7;
    localparam int C_RXRST  = 6;
    localparam int C_REPEAT = 5;
    localparam int C_TXRST  = 4;
    localparam int C_SENDFR = 3;
    localparam int C_SENDTR = 2;
    localparam int C_MSGEND = 1;
    localparam int C_SIGRST = 0;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_SEND  = 2'd1,
        ST_CYCLE = 2'd2
    } tx_state_e;
endpackage

// File: rtl/txpool_buf.sv
module txpool_buf #(
    parameter int DEPTH = 32,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic          wr_word,
    input  logic [15:0]   wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_byte,
    output logic [CW-1:0] count
);
    logic [7:0]    mem [DEPTH];
    logic          fit_byte;
    logic          fit_word;
    logic [IW-1:0] wr_idx;
    logic [IW-1:0] wr_idx_hi;

    assign fit_byte  = (count < CW'(DEPTH));
    assign fit_word  = (count <= CW'(DEPTH - 2));
    assign wr_idx    = count[IW-1:0];
    assign wr_idx_hi = wr_idx + IW'(1);
    assign rd_byte   = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            if (wr_word && fit_word) begin
                mem[wr_idx]    <= wr_data[7:0];
                mem[wr_idx_hi] <= wr_data[15:8];
            end else if (!wr_word && fit_byte) begin
                mem[wr_idx]    <= wr_data[7:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (wr_en) begin
            if (wr_word && fit_word)
                count <= count + CW'(2);
            else if (!wr_word && fit_byte)
                count <= count + CW'(1);
        end
    end
endmodule

// File: rtl/txpool_ser.sv
module txpool_ser #(
    parameter int DEPTH = 32,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          wrap,
    input  logic          bit_en,
    input  logic [CW-1:0] count,
    input  logic [7:0]    rd_byte,
    output logic [IW-1:0] rd_idx,
    output logic          tx,
    output logic          last_bit
);
    logic [2:0] bit_cnt;
    logic       last_byte;
    logic       byte_end;

    assign last_byte = ((CW'(rd_idx) + CW'(1)) == count);
    assign byte_end  = (bit_cnt == 3'd7);
    assign last_bit  = run && bit_en && byte_end && last_byte && !wrap;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            bit_cnt <= '0;
            rd_idx  <= '0;
            tx      <= 1'b1;
        end else if (bit_en) begin
            tx      <= rd_byte[bit_cnt];
            bit_cnt <= bit_cnt + 3'd1;
            if (byte_end)
                rd_idx <= last_byte ? '0 : rd_idx + IW'(1);
        end
    end
endmodule

// File: rtl/txpool_fsm.sv
module txpool_fsm
    import txpool_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [7:0]    cmd_data,
    input  logic [CW-1:0] count,
    input  logic          last_bit,
    input  logic          irq_ack,
    output tx_state_e     state,
    output logic          clr,
    output logic          irq
);
    tx_state_e state_nx;
    logic      set_irq;
    logic      stop_cmd;
    logic      have_data;
    logic      cmd_unused;

    assign stop_cmd   = cmd_wr && (cmd_data[C_TXRST] || cmd_data[C_SIGRST]);
    assign have_data  = (count != '0);
    assign cmd_unused = ^{cmd_data[C_ACKRX], cmd_data[C_RXRST], cmd_data[C_MSGEND]};

    always_comb begin
        state_nx = state;
        clr      = 1'b0;
        set_irq  = 1'b0;
        unique case (state)
            ST_LOAD: begin
                if (stop_cmd) begin
                    clr     = 1'b1;
                    set_irq = 1'b1;
                end else if (cmd_wr && have_data && cmd_data[C_SENDTR] && cmd_data[C_REPEAT]) begin
                    state_nx = ST_CYCLE;
                end else if (cmd_wr && have_data && (cmd_data[C_SENDTR] || cmd_data[C_SENDFR])) begin
                    state_nx = ST_SEND;
                end
            end
            ST_SEND: begin
                if (stop_cmd || last_bit) begin
                    state_nx = ST_LOAD;
                    clr      = 1'b1;
                    set_irq  = 1'b1;
                end
            end
            ST_CYCLE: begin
                if (stop_cmd || (cmd_wr && !cmd_data[C_REPEAT])) begin
                    state_nx = ST_LOAD;
                    clr      = 1'b1;
                    set_irq  = 1'b1;
                end
            end
            default: begin
                state_nx = ST_LOAD;
                clr      = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOAD;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b1;
        else if (set_irq) irq <= 1'b1;
        else if (irq_ack) irq <= 1'b0;
    end
endmodule

// File: rtl/txpool_top.sv
module txpool_top
    import txpool_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fifo_wr,
    input  logic        fifo_word,
    input  logic [15:0] fifo_data,
    input  logic        cmd_wr,
    input  logic [7:0]  cmd_data,
    input  logic        irq_ack,
    input  logic        tx_bit_en,
    output logic        tx_serial,
    output logic        pool_irq
);
    tx_state_e     state;
    logic          clr;
    logic          last_bit;
    logic [CW-1:0] count;
    logic [IW-1:0] rd_idx;
    logic [7:0]    rd_byte;
    logic          run;
    logic          wrap;
    logic          load_wr;

    assign run     = (state != ST_LOAD);
    assign wrap    = (state == ST_CYCLE);
    assign load_wr = fifo_wr && (state == ST_LOAD);

    txpool_fsm #(.DEPTH(DEPTH), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .count(count), .last_bit(last_bit), .irq_ack(irq_ack),
        .state(state), .clr(clr), .irq(pool_irq)
    );

    txpool_buf #(.DEPTH(DEPTH), .CW(CW), .IW(IW)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(load_wr),
        .wr_word(fifo_word), .wr_data(fifo_data), .rd_idx(rd_idx),
        .rd_byte(rd_byte), .count(count)
    );

    txpool_ser #(.DEPTH(DEPTH), .CW(CW), .IW(IW)) u_ser (
        .clk(clk), .rst_n(rst_n), .run(run), .wrap(wrap), .bit_en(tx_bit_en),
        .count(count), .rd_byte(rd_byte), .rd_idx(rd_idx),
        .tx(tx_serial), .last_bit(last_bit)
    );
endmodule

// File: rtl/txpool_chk.sv
module txpool_chk
    import txpool_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_wr,
    input logic [7:0]    cmd_data,
    input logic          irq_ack,
    input logic          tx_bit_en,
    input logic          tx_serial,
    input logic          pool_irq,
    input tx_state_e     state,
    input logic [CW-1:0] count
);
    assert_capacity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_idle_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && $past(state) == ST_LOAD) |-> tx_serial);

    assert_keep_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CYCLE && cmd_wr && cmd_data[C_REPEAT] &&
         !cmd_data[C_TXRST] && !cmd_data[C_SIGRST]) |=> state == ST_CYCLE);

    assert_reset_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && (cmd_data[C_TXRST] || cmd_data[C_SIGRST]))
        |=> (state == ST_LOAD && count == '0 && pool_irq));

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pool_irq && !irq_ack) |=> pool_irq);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_LOAD && !tx_bit_en) |=> $stable(tx_serial));
endmodule

bind txpool_top txpool_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .irq_ack(irq_ack), .tx_bit_en(tx_bit_en), .tx_serial(tx_serial),
    .pool_irq(pool_irq), .state(state), .count(count)
);

// File: tb/sim_txpool_top.sv
`timescale 1ns/1ps
module sim_txpool_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_wr = 1'b0;
    logic        fifo_word = 1'b0;
    logic [15:0] fifo_data = '0;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_data = '0;
    logic        irq_ack = 1'b0;
    logic        tx_bit_en = 1'b1;
    logic        tx_serial;
    logic        pool_irq;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] eb [0:39];
    int en = 0;

    always #5 clk = ~clk;

    txpool_top u0 (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pat(input int n, input int k);
        return 8'((k * 37 + n * 11 + 3) & 255);
    endfunction

    // all tasks start and end just after a falling edge with inputs idle
    task automatic wr_byte(input logic [7:0] b, input logic model);
        fifo_wr = 1'b1; fifo_word = 1'b0; fifo_data = {8'h00, b};
        @(negedge clk);
        fifo_wr = 1'b0;
        if (model) begin eb[en] = b; en++; end
    endtask

    task automatic wr_word(input logic [15:0] w, input logic model);
        fifo_wr = 1'b1; fifo_word = 1'b1; fifo_data = w;
        @(negedge clk);
        fifo_wr = 1'b0; fifo_word = 1'b0;
        if (model) begin eb[en] = w[7:0]; eb[en+1] = w[15:8]; en += 2; end
    endtask

    task automatic cmd(input logic [7:0] c);
        cmd_wr = 1'b1; cmd_data = c;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_data = '0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk("R8 ack clears irq", 16'(pool_irq), 16'd0);
    endtask

    task automatic bit_chk(input string req, input int i);
        @(negedge clk);
        chk(req, 16'(tx_serial), 16'(eb[(i / 8) % en][i % 8]));
    endtask

    task automatic idle_chk(input string req, input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            chk(req, 16'(tx_serial), 16'd1);
        end
    endtask

    initial begin
        #1_500_000;
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx idle", 16'(tx_serial), 16'd1);
        chk("R1 irq set", 16'(pool_irq), 16'd1);
        cmd(8'h04);
        idle_chk("R1 pool empty so no output (R9)", 3);

        // sweep every fill level, mixing byte and word writes (R2, R3, R4)
        for (int n = 1; n <= 32; n++) begin
            ack();
            en = 0;
            while (en < n) begin
                if ((n % 3 != 0) && (en + 2 <= n))
                    wr_word({pat(n, en + 1), pat(n, en)}, 1'b1);
                else
                    wr_byte(pat(n, en), 1'b1);
            end
            cmd((n % 2 == 1) ? 8'h04 : 8'h08);
            for (int i = 0; i < 8 * n; i++) begin
                if (n == 5 && i == 10) begin
                    tx_bit_en = 1'b0;
                    for (int h = 0; h < 3; h++) begin
                        @(negedge clk);
                        chk("R10 hold while enable low", 16'(tx_serial), 16'(eb[1][1]));
                    end
                    tx_bit_en = 1'b1;
                end
                bit_chk("R3 lsb-first stream", i);
            end
            chk("R4 irq after pass", 16'(pool_irq), 16'd1);
            idle_chk("R4 idle ones after pass", 2);
        end

        // R2 capacity: one-short word dropped, exact fill, then overflow dropped
        ack();
        en = 0;
        for (int k = 0; k < 31; k++) wr_byte(8'(k ^ 8'h5A), 1'b1);
        wr_word(16'hBEEF, 1'b0);
        wr_byte(8'h77, 1'b1);
        wr_byte(8'h99, 1'b0);
        wr_word(16'h1234, 1'b0);
        cmd(8'h04);
        for (int i = 0; i < 256; i++) bit_chk("R2 capacity stream", i);
        idle_chk("R2 nothing beyond 32 bytes", 2);

        // R9 writes during a pass and bits 7,6,1 ignored; R8 set wins over ack
        ack();
        en = 0;
        wr_byte(8'hA5, 1'b1);
        wr_byte(8'h0F, 1'b1);
        cmd(8'hC2);
        idle_chk("R9 bits 7,6,1 start nothing", 2);
        cmd(8'h04);
        for (int i = 0; i < 16; i++) begin
            if (i == 3) begin fifo_wr = 1'b1; fifo_data = 16'h00EE; end
            if (i == 5) begin fifo_wr = 1'b0; cmd_wr = 1'b1; cmd_data = 8'hC2; end
            if (i == 15) irq_ack = 1'b1;
            bit_chk("R9 stream unaffected", i);
            cmd_wr = 1'b0;
            irq_ack = 1'b0;
        end
        chk("R8 set beats ack", 16'(pool_irq), 16'd1);
        idle_chk("R9 pass ends normally", 1);
        en = 0;
        wr_byte(8'h3C, 1'b1);
        cmd(8'h04);
        for (int i = 0; i < 8; i++) bit_chk("R9 write during pass dropped", i);
        idle_chk("R9 only new byte sent", 3);

        // R5/R6 cyclic repeat with keep-alive and stop
        ack();
        en = 0;
        wr_byte(8'hC3, 1'b1);
        wr_word(16'h5A81, 1'b1);
        cmd(8'h24);
        for (int i = 0; i < 120; i++) begin
            if (i == 30) begin cmd_wr = 1'b1; cmd_data = 8'h24; end
            if (i == 61) begin cmd_wr = 1'b1; cmd_data = 8'h20; end
            if (i == 119) begin cmd_wr = 1'b1; cmd_data = 8'h04; end
            bit_chk("R5 cyclic replay", i);
            cmd_wr = 1'b0;
            chk("R6 irq stays clear while cycling", 16'(pool_irq), 16'(i == 119));
        end
        idle_chk("R6 stop on repeat bit clear", 2);
        cmd(8'h04);
        idle_chk("R6 pool emptied on stop", 3);

        // R7 transmitter reset mid pass
        ack();
        en = 0;
        for (int k = 0; k < 4; k++) wr_byte(pat(7, k), 1'b1);
        cmd(8'h04);
        for (int i = 0; i < 13; i++) begin
            if (i == 12) begin cmd_wr = 1'b1; cmd_data = 8'h10; end
            bit_chk("R7 stream before reset", i);
            cmd_wr = 1'b0;
        end
        chk("R7 irq on tx reset", 16'(pool_irq), 16'd1);
        idle_chk("R7 idle after tx reset", 2);
        cmd(8'h04);
        idle_chk("R7 pool cleared", 2);

        // R7 signaling reset beats repeat bit in cyclic mode
        ack();
        en = 0;
        wr_word(16'h9E17, 1'b1);
        cmd(8'h24);
        for (int i = 0; i < 21; i++) begin
            if (i == 20) begin cmd_wr = 1'b1; cmd_data = 8'h21; end
            bit_chk("R7 cyclic before reset", i);
            cmd_wr = 1'b0;
        end
        chk("R7 irq on signaling reset", 16'(pool_irq), 16'd1);
        idle_chk("R7 idle after signaling reset", 3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule